// File: doc/BRIEF.md
# Pixel Burst Write Master

This block moves a camera byte stream into a frame buffer held by a memory slave on a shared, arbitrated peripheral bus. Incoming camera bytes are packed into 32-bit words and queued in a small internal FIFO. Once enough words are queued, the block asks the arbiter for the bus. On grant it takes ownership with select and lock, and writes a burst of sequential words. The write address advances by one word per slave transfer acknowledge.

The slave may stall, request a retry, signal an error, or say nothing at all. A retry sends the master back to re-request the bus, and the transfer resumes at the word that was not acknowledged. An error, or silence beyond a fixed number of selected cycles, aborts the burst at once and sets a sticky error flag. While the flag is set, no new request is raised; software clears it with a dedicated input. The word offset wraps at the end of each frame, so every frame is written over the same buffer starting at the base address.

Top module: `pixburst_wr_master`

## Requirements
- R1: Four consecutive camera bytes form one word; the first byte lands in bits 7:0, the second in 15:8, the third in 23:16 and the fourth in 31:24.
- R2: `bus_req` stays high from the cycle it rises until a cycle in which `bus_grant` is high. In the cycle after that grant, `bus_req` is low and `bus_select`, `bus_lock` and all four `bus_be` bits are high.
- R3: A request is raised only when the FIFO holds at least `BURST_WORDS` words. A burst that sees no retry or abort writes exactly `BURST_WORDS` words.
- R4: The n-th packed word of the stream (counting from 0) is written at `BASE_ADDR + 4*(n mod FRAME_WORDS)`, where FRAME_WORDS = FRAME_COLS*FRAME_ROWS*PIX_BYTES/4. The address advances only on an acknowledged transfer.
- R5: `bus_seq` is high while any word of a burst other than its final word is presented, and low while the final word is presented.
- R6: Whenever `bus_select` is low, `bus_wdata`, `bus_addr`, `bus_be`, `bus_lock` and `bus_seq` are all zero. `bus_lock` stays high for every cycle of a burst, with no limit on the number of acknowledged words or stall cycles.
- R7: `slv_retry` during a selected cycle drops select in the next cycle and raises `bus_req` again. After re-grant, the burst resumes with the unacknowledged word and keeps its remaining beat count.
- R8: `slv_err` during a selected cycle drops select and lock in the next cycle, sets `err_flag`, and leaves the unacknowledged word queued.
- R9: After `TIMEOUT_CYCLES` consecutive selected cycles with no acknowledge, retry or error, the burst aborts in the same way as in R8.
- R10: While `err_flag` is high, `bus_req` stays low even if enough words are queued. A cycle with `err_clr` high clears the flag, and writing then resumes at the first unwritten word.
- R11: A cycle with `cam_sof` high discards any partially packed bytes. The byte presented in that cycle, if any, becomes the first byte of a new word.
- R12: `slv_ack` outside a selected cycle has no effect on the queued words or on the write address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cam_valid | input | 1 | Camera byte present this cycle |
| cam_byte | input | 8 | Camera byte |
| cam_sof | input | 1 | Start of frame; realigns byte packing |
| bus_grant | input | 1 | Arbiter grant |
| slv_ack | input | 1 | Slave transfer acknowledge |
| slv_retry | input | 1 | Slave retry request |
| slv_err | input | 1 | Slave error acknowledge |
| err_clr | input | 1 | Clears the sticky error flag |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_select | output | 1 | Master owns and drives the bus |
| bus_lock | output | 1 | Bus lock held for the burst |
| bus_seq | output | 1 | Next transfer continues the sequential burst |
| bus_be | output | 4 | Byte enables |
| bus_addr | output | ADDR_W | Write address |
| bus_wdata | output | 32 | Write data |
| err_flag | output | 1 | Sticky abort status |

## Verification
The embedded properties check, on every cycle, the protocol relations between ports. These are: request held until grant, ownership signals in the cycle after grant, quiet outputs when not selected, the address step after a non-final acknowledge, bus release after the final beat, re-request after retry, release and flag after an error, the bound on silent selected cycles, and a blocked request while the flag is set. The directed scenarios show what no single-cycle relation can. They confirm that every written word carries the right packed bytes at the right frame-wrapped address, and that the burst count follows the threshold. They also show that a retry or abort loses and duplicates no word, that the timeout fires after exactly the configured number of cycles, that stray acknowledges leave the queue untouched, and that frame start discards a partial word.

// File: rtl/pixburst_pkg.sv
package pixburst_pkg;
  localparam int unsigned BYTES_PER_WORD = 4;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_BURST = 2'd2
  } mst_state_e;
endpackage

// File: rtl/pixburst_packer.sv
module pixburst_packer #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              in_sof,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_word
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [LANE_W-1:0] lane_q;
  logic [LANE_W-1:0] eff_lane;
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] merged;

  // frame start restarts packing at lane 0 (R11)
  assign eff_lane = in_sof ? '0 : lane_q;

  always_comb begin
    merged = word_q;
    merged[{eff_lane, 3'b000} +: 8] = in_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q    <= '0;
      word_q    <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        word_q <= merged;
        if (eff_lane == LANE_W'(LANES - 1)) begin
          lane_q    <= '0;
          out_valid <= 1'b1;
          out_word  <= merged;
        end else begin
          lane_q <= eff_lane + LANE_W'(1);
        end
      end else if (in_sof) begin
        lane_q <= '0;
      end
    end
  end

  // R1: a word only completes on a cycle that carried a byte
  p_word_from_byte_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid))
    else $error("packed word without an input byte");
endmodule

// File: rtl/pixburst_fifo.sv
module pixburst_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       pop,
  output logic [DATA_W-1:0]          head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign do_push = push && (count != CNT_W'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  p_fifo_bound_r3: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH))
    else $error("fifo count above depth");

  // R12: the controller never pops an empty queue
  p_pop_nonempty_r12: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0))
    else $error("pop from empty fifo");
endmodule

// File: rtl/pixburst_burst_ctl.sv
module pixburst_burst_ctl
  import pixburst_pkg::*;
#(
  parameter int                ADDR_W         = 32,
  parameter int                DATA_W         = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR      = 'h0010_0000,
  parameter int                FRAME_WORDS    = 153600,
  parameter int                BURST_WORDS    = 8,
  parameter int                TIMEOUT_CYCLES = 16,
  parameter int                CNT_W          = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    fifo_count,
  input  logic [DATA_W-1:0]   fifo_head,
  output logic                fifo_pop,
  input  logic                grant,
  input  logic                ack,
  input  logic                retry,
  input  logic                err,
  input  logic                err_clr,
  output logic                req,
  output logic                select,
  output logic                lock,
  output logic                seq,
  output logic [DATA_W/8-1:0] be,
  output logic [ADDR_W-1:0]   addr,
  output logic [DATA_W-1:0]   wdata,
  output logic                err_flag
);
  localparam int BEAT_W = $clog2(BURST_WORDS + 1);
  localparam int IDX_W  = $clog2(FRAME_WORDS);
  localparam int TO_W   = $clog2(TIMEOUT_CYCLES);
  localparam int WORD_BYTES = DATA_W / 8;

  mst_state_e        state;
  logic [BEAT_W-1:0] beats_left;
  logic [IDX_W-1:0]  word_idx;
  logic [ADDR_W-1:0] addr_q;
  logic [TO_W-1:0]   wait_q;
  logic              err_q;
  logic              in_burst, timeout_hit, abort, last_beat;

  assign in_burst    = (state == ST_BURST);
  assign last_beat   = (beats_left == BEAT_W'(1));
  assign timeout_hit = in_burst && !ack && !retry && !err &&
                       (wait_q == TO_W'(TIMEOUT_CYCLES - 1));
  assign abort       = in_burst && (err || timeout_hit);
  assign fifo_pop    = in_burst && ack && !retry && !err;

  assign req      = (state == ST_REQ);
  assign select   = in_burst;
  assign lock     = in_burst;
  assign seq      = in_burst && !last_beat;
  assign be       = {WORD_BYTES{in_burst}};
  assign addr     = in_burst ? addr_q : '0;
  assign wdata    = in_burst ? fifo_head : '0;
  assign err_flag = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      beats_left <= '0;
      word_idx   <= '0;
      addr_q     <= BASE_ADDR;
      wait_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      if (abort)        err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (!err_q && fifo_count >= CNT_W'(BURST_WORDS)) begin
            state      <= ST_REQ;
            beats_left <= BEAT_W'(BURST_WORDS);
          end
        end
        ST_REQ: begin
          if (grant) begin
            state  <= ST_BURST;
            wait_q <= '0;
          end
        end
        ST_BURST: begin
          if (abort) begin
            state <= ST_IDLE;
          end else if (retry) begin
            state <= ST_REQ;
          end else if (ack) begin
            wait_q     <= '0;
            beats_left <= beats_left - BEAT_W'(1);
            if (last_beat) state <= ST_IDLE;
            if (word_idx == IDX_W'(FRAME_WORDS - 1)) begin
              word_idx <= '0;
              addr_q   <= BASE_ADDR;
            end else begin
              word_idx <= word_idx + IDX_W'(1);
              addr_q   <= addr_q + ADDR_W'(WORD_BYTES);
            end
          end else begin
            wait_q <= wait_q + TO_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // independent count of silent selected cycles, used only by the checks
  logic [TO_W:0] silent_q;
  always_ff @(posedge clk) begin
    if (rst) silent_q <= '0;
    else if (select && !ack && !retry && !err) silent_q <= silent_q + (TO_W+1)'(1);
    else silent_q <= '0;
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    req && !grant |=> req)
    else $error("request dropped before grant");

  p_grant_take_r2: assert property (@(posedge clk) disable iff (rst)
    req && grant |=> !req && select && lock && (be == '1))
    else $error("ownership not taken after grant");

  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    select && ack && !retry && !err && seq |=>
      select && ((addr == $past(addr) + ADDR_W'(WORD_BYTES)) || (addr == BASE_ADDR)))
    else $error("address did not step by one word");

  p_last_release_r5: assert property (@(posedge clk) disable iff (rst)
    select && ack && !retry && !err && !seq |=> !select && !lock)
    else $error("bus held after final beat");

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !select |-> (wdata == '0) && (addr == '0) && (be == '0) && !lock && !seq)
    else $error("bus driven while not selected");

  p_retry_back_r7: assert property (@(posedge clk) disable iff (rst)
    select && retry && !err |=> req && !select)
    else $error("no re-request after retry");

  p_error_abort_r8: assert property (@(posedge clk) disable iff (rst)
    select && err |=> !select && !req && err_flag)
    else $error("error did not abort");

  p_timeout_bound_r9: assert property (@(posedge clk) disable iff (rst)
    select |-> (silent_q < (TO_W+1)'(TIMEOUT_CYCLES)))
    else $error("selected too long without response");

  p_flag_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> !req)
    else $error("request raised while error flag set");
endmodule

// File: rtl/pixburst_wr_master.sv
module pixburst_wr_master
  import pixburst_pkg::*;
#(
  parameter int                ADDR_W         = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR      = 'h0010_0000,
  parameter int                FRAME_COLS     = 640,
  parameter int                FRAME_ROWS     = 480,
  parameter int                PIX_BYTES      = 2,
  parameter int                BURST_WORDS    = 8,
  parameter int                FIFO_DEPTH     = 32,
  parameter int                TIMEOUT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cam_valid,
  input  logic [7:0]        cam_byte,
  input  logic              cam_sof,
  input  logic              bus_grant,
  input  logic              slv_ack,
  input  logic              slv_retry,
  input  logic              slv_err,
  input  logic              err_clr,
  output logic              bus_req,
  output logic              bus_select,
  output logic              bus_lock,
  output logic              bus_seq,
  output logic [3:0]        bus_be,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic              err_flag
);
  localparam int DATA_W      = 8 * BYTES_PER_WORD;
  localparam int FRAME_WORDS = (FRAME_COLS * FRAME_ROWS * PIX_BYTES) / BYTES_PER_WORD;
  localparam int CNT_W       = $clog2(FIFO_DEPTH + 1);

  logic              pk_valid;
  logic [DATA_W-1:0] pk_word;
  logic [DATA_W-1:0] q_head;
  logic [CNT_W-1:0]  q_count;
  logic              q_pop;

  pixburst_packer #(.DATA_W(DATA_W)) u_packer (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (cam_valid),
    .in_byte   (cam_byte),
    .in_sof    (cam_sof),
    .out_valid (pk_valid),
    .out_word  (pk_word)
  );

  pixburst_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (pk_valid),
    .push_data (pk_word),
    .pop       (q_pop),
    .head      (q_head),
    .count     (q_count)
  );

  pixburst_burst_ctl #(
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W),
    .BASE_ADDR      (BASE_ADDR),
    .FRAME_WORDS    (FRAME_WORDS),
    .BURST_WORDS    (BURST_WORDS),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .CNT_W          (CNT_W)
  ) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .fifo_count (q_count),
    .fifo_head  (q_head),
    .fifo_pop   (q_pop),
    .grant      (bus_grant),
    .ack        (slv_ack),
    .retry      (slv_retry),
    .err        (slv_err),
    .err_clr    (err_clr),
    .req        (bus_req),
    .select     (bus_select),
    .lock       (bus_lock),
    .seq        (bus_seq),
    .be         (bus_be),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .err_flag   (err_flag)
  );
endmodule

// File: tb/tb_pixburst_wr_master.sv
module tb_pixburst_wr_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam int FW = 16;   // 8 cols * 4 rows * 2 bytes / 4
  localparam int B  = 4;

  logic clk = 0, rst = 1;
  logic cam_valid = 0, cam_sof = 0, err_clr = 0;
  logic [7:0] cam_byte = 0;
  logic bus_grant, slv_ack, slv_retry, slv_err;
  logic bus_req, bus_select, bus_lock, bus_seq, err_flag;
  logic [3:0] bus_be;
  logic [31:0] bus_addr, bus_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixburst_wr_master #(
    .ADDR_W(32), .BASE_ADDR(BASE), .FRAME_COLS(8), .FRAME_ROWS(4), .PIX_BYTES(2),
    .BURST_WORDS(B), .FIFO_DEPTH(16), .TIMEOUT_CYCLES(16)
  ) dut (
    .clk(clk), .rst(rst), .cam_valid(cam_valid), .cam_byte(cam_byte), .cam_sof(cam_sof),
    .bus_grant(bus_grant), .slv_ack(slv_ack), .slv_retry(slv_retry), .slv_err(slv_err),
    .err_clr(err_clr), .bus_req(bus_req), .bus_select(bus_select), .bus_lock(bus_lock),
    .bus_seq(bus_seq), .bus_be(bus_be), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .err_flag(err_flag)
  );

  int chk_cnt = 0, fail_cnt = 0;
  logic [31:0] exp_data [512];
  int exp_wr = 0, wr_idx = 0, byte_seq = 0, beat = 0;
  int stall = 0, grant_delay = 0, req_run = 0, wait_cnt = 0;
  int burst_starts = 0, sel_run = 0, last_run = 0, idle_bad = 0;
  bit silent = 0, stray_ack = 0, prev_sel = 0;
  bit retry_arm = 0, err_arm = 0, chk_retry = 0, chk_err = 0, retry_seen = 0, err_seen = 0;
  int retry_word = 0, err_word = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // arbiter and memory slave model
  initial begin
    bus_grant = 0; slv_ack = 0; slv_retry = 0; slv_err = 0;
    forever begin
      @(negedge clk);
      slv_ack = 0; slv_retry = 0; slv_err = 0;
      if (bus_req) begin req_run++; bus_grant = (req_run > grant_delay); end
      else begin req_run = 0; bus_grant = 0; end
      if (chk_retry) begin
        check(bus_req && !bus_select, "R7 re-request after retry", {30'd0, bus_req, bus_select}, 32'h2);
        chk_retry = 0;
      end
      if (chk_err) begin
        check(!bus_select && !bus_lock && !bus_req && err_flag, "R8 abort on error",
              {28'd0, bus_select, bus_lock, bus_req, err_flag}, 32'h1);
        chk_err = 0;
      end
      if (bus_select && !prev_sel) burst_starts++;
      if (!bus_select && prev_sel) begin last_run = sel_run; if (silent) beat = 0; end
      if (bus_select) sel_run = prev_sel ? sel_run + 1 : 1;
      if (!bus_select) begin
        if (bus_wdata != 0 || bus_addr != 0 || bus_be != 0 || bus_lock || bus_seq) idle_bad++;
        slv_ack = stray_ack;
        wait_cnt = 0;
      end else if (!silent) begin
        wait_cnt++;
        if (wait_cnt > stall) begin
          wait_cnt = 0;
          if (retry_arm && wr_idx == retry_word) begin
            slv_retry = 1; retry_arm = 0; chk_retry = 1; retry_seen = 1;
          end else if (err_arm && wr_idx == err_word) begin
            slv_err = 1; err_arm = 0; chk_err = 1; err_seen = 1; beat = 0;
          end else begin
            check(wr_idx < exp_wr, "R12 write with no queued word", wr_idx, exp_wr);
            check(bus_addr == BASE + 32'(4 * (wr_idx % FW)), "R4 write address",
                  bus_addr, BASE + 32'(4 * (wr_idx % FW)));
            check(bus_wdata == exp_data[wr_idx], "R1 packed data", bus_wdata, exp_data[wr_idx]);
            check(bus_seq == (beat != B - 1), "R5 sequential flag", bus_seq, beat != B - 1);
            check(bus_lock && bus_be == 4'hF && !bus_req, "R6 lock and enables held",
                  {27'd0, bus_lock, bus_be}, 32'h1F);
            slv_ack = 1;
            wr_idx++;
            beat = (beat == B - 1) ? 0 : beat + 1;
          end
        end
      end
      prev_sel = bus_select;
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); cam_valid = 1; cam_byte = b;
    @(negedge clk); cam_valid = 0;
  endtask

  task automatic push_words(input int n);
    for (int w = 0; w < n; w++) begin
      logic [31:0] word;
      for (int k = 0; k < 4; k++) begin
        logic [7:0] nb;
        nb = 8'((byte_seq * 37 + 11) & 255);
        byte_seq++;
        word[8*k +: 8] = nb;
        send_byte(nb);
      end
      exp_data[exp_wr] = word;
      exp_wr++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_drain(input string tag);
    for (int i = 0; i < 3000 && !(wr_idx == exp_wr && !bus_select); i++) @(negedge clk);
    check(wr_idx == exp_wr, tag, wr_idx, exp_wr);
  endtask

  task automatic pulse_clear();
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!bus_req && !bus_select && !err_flag && bus_addr == 0 && bus_wdata == 0,
          "R6 reset state quiet", {27'd0, bus_req, bus_select, err_flag, 2'd0}, 0);
  endtask

  task automatic t_threshold();
    int s0;
    s0 = burst_starts;
    push_words(3);
    idle(10);
    check(!bus_req && !bus_select && wr_idx == 0, "R3 no request below threshold",
          {30'd0, bus_req, bus_select}, 0);
    push_words(1);
    wait_drain("R3 threshold burst drained");
    check(burst_starts - s0 == 1, "R3 one burst for threshold words", burst_starts - s0, 1);
  endtask

  task automatic t_stream_stall();
    int s0;
    s0 = burst_starts;
    stall = 3;
    push_words(8);
    wait_drain("R4 stalled stream drained");
    check(burst_starts - s0 == 2, "R3 burst length under stalls", burst_starts - s0, 2);
    stall = 0;
  endtask

  task automatic t_frame_wrap();
    push_words(8);
    wait_drain("R4 frame wrap drained");
    check(wr_idx > FW, "R4 writes crossed frame end", wr_idx, FW + 1);
  endtask

  task automatic t_grant_delay();
    bit ok;
    grant_delay = 5;
    ok = 1;
    fork push_words(4); join_none
    while (!bus_req) @(negedge clk);
    for (int k = 2; k <= 6; k++) begin
      @(negedge clk);
      ok &= bus_req && !bus_select;
    end
    check(ok, "R2 request held until grant", ok, 1);
    @(negedge clk);
    check(!bus_req && bus_select && bus_lock && bus_be == 4'hF, "R2 ownership after grant",
          {26'd0, bus_req, bus_select, bus_lock, 1'b0, bus_be == 4'hF, 1'b0}, 32'h1A);
    wait fork;
    wait_drain("R2 delayed grant drained");
    grant_delay = 0;
  endtask

  task automatic t_retry();
    int s0;
    s0 = burst_starts;
    retry_seen = 0;
    retry_word = wr_idx + 1;
    retry_arm = 1;
    push_words(4);
    wait_drain("R7 retry burst drained");
    check(retry_seen, "R7 retry was issued", retry_seen, 1);
    check(burst_starts - s0 == 2, "R7 burst resumed after re-grant", burst_starts - s0, 2);
  endtask

  task automatic t_error();
    int w0;
    err_seen = 0;
    w0 = wr_idx;
    err_word = wr_idx + 2;
    err_arm = 1;
    push_words(4);
    for (int i = 0; i < 500 && !err_seen; i++) @(negedge clk);
    push_words(2);
    idle(10);
    check(err_flag && !bus_req && !bus_select, "R10 flag blocks request",
          {29'd0, err_flag, bus_req, bus_select}, 32'h4);
    check(wr_idx == w0 + 2, "R8 no write after error", wr_idx, w0 + 2);
    pulse_clear();
    wait_drain("R10 resume after clear");
    check(!err_flag, "R10 flag cleared", err_flag, 0);
  endtask

  task automatic t_timeout();
    int w0, s0;
    w0 = wr_idx;
    s0 = burst_starts;
    silent = 1;
    push_words(4);
    for (int i = 0; i < 500 && !(burst_starts > s0 && !bus_select); i++) @(negedge clk);
    check(last_run == 16, "R9 selected cycles before timeout", last_run, 16);
    check(err_flag, "R9 timeout sets flag", err_flag, 1);
    idle(10);
    check(!bus_req && wr_idx == w0, "R10 no request after timeout", {31'd0, bus_req}, 0);
    silent = 0;
    pulse_clear();
    wait_drain("R9 resume after timeout");
  endtask

  task automatic t_stray_ack();
    int f0;
    f0 = fail_cnt;
    stray_ack = 1;
    push_words(3);
    idle(8);
    stray_ack = 0;
    push_words(1);
    wait_drain("R12 drained after stray acks");
    check(fail_cnt == f0, "R12 stray acks left queue intact", fail_cnt, f0);
  endtask

  task automatic t_sof();
    int f0;
    f0 = fail_cnt;
    send_byte(8'hEE);
    send_byte(8'hDD);
    @(negedge clk); cam_sof = 1;
    @(negedge clk); cam_sof = 0;
    push_words(4);
    wait_drain("R11 drained after frame start");
    check(fail_cnt == f0, "R11 partial bytes discarded", fail_cnt, f0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fail_cnt++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_threshold();
    t_stream_stall();
    t_frame_wrap();
    t_grant_delay();
    t_retry();
    t_error();
    t_timeout();
    t_stray_ack();
    t_sof();
    check(idle_bad == 0, "R6 outputs quiet when not selected", idle_bad, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end
endmodule